// File: doc/BRIEF.md
# PHY Address Discovery Scanner

This block searches the station management bus for an attached PHY. Each probe asks an external MDIO read engine for management register 1, the basic status register, at one PHY address. The returned value is then judged by a capability test. When a preferred address is supplied, that address is probed first. If it fails, or none was given, the block sweeps every address from the highest (31) down to 0 and stops at the first one that passes.

A one-cycle start pulse launches a scan. At the end, a one-cycle `done` pulse appears together with `found` and `phy_addr`, and both of those hold until the next accepted start. The read engine is reached through two valid/ready channels. The request channel (`req_*`) keeps its address and register fields steady while `req_ready` is low. The response channel (`rsp_*`) is accepted only while the block waits for a reply. Exactly one read is ever outstanding.

Top module: `phy_addr_scanner`

## Requirements
- R1: Every read request carries register number 1 on `req_reg` and the address under test on `req_phy`.
- R2: A status value passes only if it is not 0xFFFF and bits 12, 11 and 3 (mask 0x1808) are all set. Any other value counts as a failing address.
- R3: With `pref_valid` high at start, `pref_addr` is probed first. If it passes, the scan ends with `found`=1 and `phy_addr`=`pref_addr`, and no further request is issued.
- R4: Without a preferred address, or after the preferred one fails, addresses 31, 30, …, 0 are probed in that order. The first passing address is reported with `found`=1.
- R5: If no probed address passes, the scan ends with `done`=1, `found`=0 and `phy_addr`=0.
- R6: While `req_valid` is high and `req_ready` is low, `req_valid` and `req_phy` hold. A new request is raised only after the previous response has been accepted.
- R7: A response with `rsp_timeout`=1 counts as a failing address whatever its data, and the scan continues.
- R8: A start pulse arriving while a scan is running has no effect on the request sequence or on the result.
- R9: `done` is high for exactly one cycle per scan. `found` and `phy_addr` stay unchanged from then until the next accepted start, which clears them to 0.
- R10: After reset, `done`, `found`, `phy_addr`, `req_valid` and `rsp_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan (one-cycle pulse, taken only when idle) |
| pref_valid | input | 1 | A preferred address is supplied |
| pref_addr | input | 5 | Preferred PHY address |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read engine accepts the request |
| req_phy | output | 5 | PHY address of the request |
| req_reg | output | 5 | Register number of the request |
| rsp_valid | input | 1 | Read response valid |
| rsp_ready | output | 1 | Block accepts the response |
| rsp_data | input | 16 | Register value read |
| rsp_timeout | input | 1 | Read engine gave up on this read |
| done | output | 1 | Scan finished (one-cycle pulse) |
| found | output | 1 | A passing PHY was found |
| phy_addr | output | 5 | Address of the PHY found |

## Verification
A single valid PHY is swept across all 32 addresses with no preferred address, which shows whether the downward ordering and early stop are exact at every position, including address 0. The preferred address is swept across all 32 values while being valid, which separates the single-probe path from the full scan. Near-miss status values that lack one capability bit, plus 0xFFFF and its complement-like patterns, show whether the validity test is applied bit by bit. Empty buses, timed-out reads, a failing preferred address that repeats in the sweep, a busy-time start pulse and a stalling request channel cover the not-found, timeout, ignore and back-pressure rules.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;
  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_ISSUE = 2'd1,
    SC_AWAIT = 2'd2
  } scan_state_e;
endpackage

// File: rtl/phy_scan_status_check.sv
// Judges one status read: passes only for a real, capable PHY.
module phy_scan_status_check #(
  parameter int                DATA_W   = 16,
  parameter logic [DATA_W-1:0] REQ_MASK = 16'h1808
) (
  input  logic [DATA_W-1:0] status,
  input  logic              timed_out,
  output logic              accept
);
  logic bus_floating;
  logic caps_present;

  assign bus_floating = &status;
  assign caps_present = ((status & REQ_MASK) == REQ_MASK);
  assign accept       = !timed_out && !bus_floating && caps_present;
endmodule

// File: rtl/phy_scan_addr_step.sv
// Holds the address under test: preferred probe, then a descending sweep.
module phy_scan_addr_step #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_pref,
  input  logic              load_top,
  input  logic              step,
  input  logic [ADDR_W-1:0] pref_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              in_pref,
  output logic              at_floor
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      in_pref  <= 1'b0;
    end else if (load_pref) begin
      cur_addr <= pref_addr;
      in_pref  <= 1'b1;
    end else if (load_top) begin
      cur_addr <= TOP_ADDR;
      in_pref  <= 1'b0;
    end else if (step) begin
      if (in_pref) begin
        cur_addr <= TOP_ADDR;
        in_pref  <= 1'b0;
      end else begin
        cur_addr <= cur_addr - 1'b1;
      end
    end
  end

  assign at_floor = !in_pref && (cur_addr == '0);

  AST_PREF_THEN_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && in_pref) |=> (!in_pref && (cur_addr == TOP_ADDR))); // R4
  AST_SWEEP_DESCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !in_pref && !load_pref && !load_top) |=> (cur_addr == $past(cur_addr) - 1'b1)); // R4
endmodule

// File: rtl/phy_addr_scanner.sv
module phy_addr_scanner
  import phy_scan_pkg::*;
#(
  parameter int                ADDR_W      = 5,
  parameter int                REG_W       = 5,
  parameter int                DATA_W      = 16,
  parameter int                DETECT_REG  = 1,
  parameter logic [DATA_W-1:0] DETECT_MASK = 16'h1808
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pref_valid,
  input  logic [ADDR_W-1:0] pref_addr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_phy,
  output logic [REG_W-1:0]  req_reg,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              rsp_timeout,
  output logic              done,
  output logic              found,
  output logic [ADDR_W-1:0] phy_addr
);
  scan_state_e       st;
  logic              take;
  logic              accept;
  logic              step;
  logic              load_pref;
  logic              load_top;
  logic              in_pref;
  logic              at_floor;
  logic [ADDR_W-1:0] cur_addr;

  assign take      = rsp_valid && rsp_ready;
  assign load_pref = (st == SC_IDLE) && start && pref_valid;
  assign load_top  = (st == SC_IDLE) && start && !pref_valid;
  assign step      = take && !accept && !at_floor;

  phy_scan_status_check #(
    .DATA_W   (DATA_W),
    .REQ_MASK (DETECT_MASK)
  ) u_check (
    .status    (rsp_data),
    .timed_out (rsp_timeout),
    .accept    (accept)
  );

  phy_scan_addr_step #(
    .ADDR_W (ADDR_W)
  ) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_pref (load_pref),
    .load_top  (load_top),
    .step      (step),
    .pref_addr (pref_addr),
    .cur_addr  (cur_addr),
    .in_pref   (in_pref),
    .at_floor  (at_floor)
  );

  assign req_valid = (st == SC_ISSUE);
  assign rsp_ready = (st == SC_AWAIT);
  assign req_phy   = cur_addr;
  assign req_reg   = REG_W'(DETECT_REG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SC_IDLE;
      done     <= 1'b0;
      found    <= 1'b0;
      phy_addr <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        SC_IDLE: begin
          if (start) begin
            found    <= 1'b0;
            phy_addr <= '0;
            st       <= SC_ISSUE;
          end
        end
        SC_ISSUE: begin
          if (req_ready) st <= SC_AWAIT;
        end
        SC_AWAIT: begin
          if (take) begin
            if (accept) begin
              done     <= 1'b1;
              found    <= 1'b1;
              phy_addr <= cur_addr;
              st       <= SC_IDLE;
            end else if (at_floor) begin
              done <= 1'b1;
              st   <= SC_IDLE;
            end else begin
              st <= SC_ISSUE;
            end
          end
        end
        default: st <= SC_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_phy))); // R6
  AST_PASS_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && accept) |=> (done && found && (phy_addr == $past(req_phy)))); // R3
  AST_ALLONES_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (rsp_data == '1)) |=> !(done && found)); // R2
  AST_TIMEOUT_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rsp_timeout) |=> !(done && found)); // R7
  AST_EXHAUSTED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !accept && at_floor) |=> (done && !found && (phy_addr == '0))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == SC_IDLE) && !start) |=> ($stable(found) && $stable(phy_addr))); // R9
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == SC_ISSUE) && start && !req_ready) |=> (req_valid && $stable(req_phy))); // R8
endmodule

// File: tb/phy_addr_scanner_tb_top.sv
`timescale 1ns/1ps
module phy_addr_scanner_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        pref_valid = 1'b0;
  logic [4:0]  pref_addr = '0;
  logic        req_valid, req_ready, rsp_ready, done, found;
  logic [4:0]  req_phy, req_reg, phy_addr;
  logic        rsp_valid, rsp_timeout;
  logic [15:0] rsp_data;

  always #2.5 clk = ~clk;

  phy_addr_scanner dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pref_valid(pref_valid), .pref_addr(pref_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_phy(req_phy), .req_reg(req_reg),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_timeout(rsp_timeout),
    .done(done), .found(found), .phy_addr(phy_addr)
  );

  // Bus model: per-address status and timeout flag.
  logic [15:0] phy_mem [32];
  logic        phy_to  [32];
  logic        stall_en = 1'b0;
  logic [1:0]  cyc;
  logic        busy, held;
  logic [4:0]  cur, held_phy;
  int          lat_cnt;
  int          log_addr [4096];
  int          log_n = 0;
  int          reg_err = 0;
  int          hold_err = 0;
  int          done_cnt = 0;
  int          total = 0;
  int          fails = 0;
  int          wd = 0;

  assign req_ready = rst_n && !busy && (!stall_en || cyc != 2'd0);

  always @(posedge clk) begin
    cyc <= cyc + 2'd1;
    if (!rst_n) begin
      busy <= 1'b0; rsp_valid <= 1'b0; rsp_data <= '0; rsp_timeout <= 1'b0;
      held <= 1'b0; held_phy <= '0; cur <= '0; lat_cnt <= 0; cyc <= '0;
    end else begin
      if (req_valid && req_ready) begin
        busy    <= 1'b1;
        cur     <= req_phy;
        lat_cnt <= int'(req_phy) % 3 + 1;
        if (log_n < 4096) log_addr[log_n] <= int'(req_phy);
        log_n   <= log_n + 1;
        if (req_reg != 5'd1) reg_err <= reg_err + 1;
      end else if (busy && !rsp_valid) begin
        if (lat_cnt == 0) begin
          rsp_valid   <= 1'b1;
          rsp_data    <= phy_mem[cur];
          rsp_timeout <= phy_to[cur];
        end else lat_cnt <= lat_cnt - 1;
      end else if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
        busy      <= 1'b0;
      end
      if (req_valid && !req_ready) begin held <= 1'b1; held_phy <= req_phy; end
      else held <= 1'b0;
      if (held && (!req_valid || req_phy != held_phy)) hold_err <= hold_err + 1;
    end
  end

  always @(negedge clk) if (done) done_cnt <= done_cnt + 1;

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit passes(input int a);
    return !phy_to[a] && phy_mem[a] != 16'hFFFF && ((phy_mem[a] & 16'h1808) == 16'h1808);
  endfunction

  task automatic fill(input logic [15:0] v);
    for (int i = 0; i < 32; i++) begin phy_mem[i] = v; phy_to[i] = 1'b0; end
  endtask

  task automatic run_scan(input string tag, input bit pv, input int pa, input bit stl, input bit mid);
    int seq [40];
    int n, base, dc0, re0, he0, w, ea, ga;
    bit ef, gf, same;
    n = 0; ef = 0; ea = 0;
    if (pv) begin
      seq[n++] = pa;
      if (passes(pa)) begin ef = 1; ea = pa; end
    end
    if (!ef) for (int a = 31; a >= 0; a--) begin
      seq[n++] = a;
      if (passes(a)) begin ef = 1; ea = a; break; end
    end
    @(negedge clk);
    stall_en = stl;
    base = log_n; dc0 = done_cnt; re0 = reg_err; he0 = hold_err;
    pref_valid = pv; pref_addr = 5'(pa); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (mid) begin
      repeat (3) @(negedge clk);
      start = 1'b1; pref_valid = 1'b1; pref_addr = 5'd0;
      @(negedge clk); start = 1'b0;
    end
    w = 0;
    while (!done && w < 3000) begin @(negedge clk); w++; end
    chk({tag, " completion"}, done === 1'b1, int'(done), 1);
    gf = found; ga = int'(phy_addr);
    chk({tag, " found"}, gf == ef, int'(gf), int'(ef));
    chk({tag, " address"}, ga == ea, ga, ea);
    chk("R4 request count", (log_n - base) == n, log_n - base, n);
    same = ((log_n - base) == n);
    for (int i = 0; i < n && same; i++)
      if (log_addr[base + i] != seq[i]) begin
        same = 0;
        chk("R4 request order", 0, log_addr[base + i], seq[i]);
      end
    if (same) chk("R4 request order", 1, 0, 0);
    chk("R1 register number", reg_err == re0, reg_err - re0, 0);
    chk("R6 request hold", hold_err == he0, hold_err - he0, 0);
    repeat (6) @(negedge clk);
    chk("R9 done pulse count", (done_cnt - dc0) == 1, done_cnt - dc0, 1);
    chk("R9 result held", found == gf && int'(phy_addr) == ga && !done, int'(phy_addr), ga);
    stall_en = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        total++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
    end
  end

  initial begin
    fill(16'hFFFF);
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 done", done == 1'b0, int'(done), 0);
    chk("R10 found", found == 1'b0, int'(found), 0);
    chk("R10 phy_addr", phy_addr == '0, int'(phy_addr), 0);
    chk("R10 req_valid", req_valid == 1'b0, int'(req_valid), 0);
    chk("R10 rsp_ready", rsp_ready == 1'b0, int'(rsp_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: single capable PHY at every address, no preference
    for (int t = 0; t < 32; t++) begin
      fill(16'hFFFF); phy_mem[t] = 16'h7849;
      run_scan("R4 sweep", 0, 0, t[0], 0);
    end
    // R3: valid preferred address at every position
    for (int p = 0; p < 32; p++) begin
      fill(16'hFFFF); phy_mem[p] = 16'h1808; phy_mem[(p + 7) % 32] = 16'h1808;
      run_scan("R3 preferred", 1, p, p[0], 0);
    end
    // R3/R4: preferred fails, sweep follows (preferred probed again in sweep)
    fill(16'h0000); phy_mem[10] = 16'h1808;
    run_scan("R3 pref fails", 1, 3, 0, 0);
    fill(16'h0000); phy_mem[9] = 16'h1808;
    run_scan("R4 pref 31 fails", 1, 31, 1, 0);
    // R2: near misses, all-ones, then an exact match
    fill(16'h0000);
    phy_mem[31] = 16'h1800; phy_mem[30] = 16'h1008; phy_mem[29] = 16'h0808;
    phy_mem[28] = 16'hFFFF; phy_mem[27] = 16'hE7F7; phy_mem[26] = 16'h1808;
    run_scan("R2 validity", 0, 0, 0, 0);
    // R5: nothing answers
    fill(16'hFFFF);
    run_scan("R5 empty all-ones", 0, 0, 0, 0);
    fill(16'h0000);
    run_scan("R5 empty zeros", 1, 17, 1, 0);
    // R7: timed-out reads fail even with good data
    fill(16'hFFFF); phy_mem[20] = 16'h1808; phy_to[20] = 1'b1; phy_mem[12] = 16'h1808;
    run_scan("R7 timeout sweep", 0, 0, 0, 0);
    run_scan("R7 timeout pref", 1, 20, 1, 0);
    fill(16'h1808); for (int i = 0; i < 32; i++) phy_to[i] = 1'b1;
    run_scan("R7 all timeout", 0, 0, 0, 0);
    // R8: start while busy is ignored
    fill(16'hFFFF); phy_mem[0] = 16'h1808;
    run_scan("R8 busy start", 0, 0, 0, 1);
    fill(16'hFFFF); phy_mem[2] = 16'h1808;
    run_scan("R8 busy start stall", 1, 5, 1, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule